// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block lets a clocked host read and write an external asynchronous static RAM of 1M words by 4 bits. The host offers one transaction at a time on a valid/ready request channel: a 20-bit address, a write flag and 4-bit write data. Each accepted transaction ends with a single-cycle response pulse. For a read, that pulse carries the captured data.

On the memory side the controller drives the active-low select, write and output strobes, the address lines, and a 4-bit data bus. The data bus is split into an output value, a tri-state enable and an input value, so the pad buffers stay outside the block. Every phase length is a whole number of clocks, worked out by ceiling division from picosecond timing parameters and the clock period, with a floor of one cycle. All strobes come straight from flops.

Request rules: the host holds `req_valid` and all request fields steady until it sees `req_ready` high at a rising edge. The transfer happens on that edge. `req_ready` is low for the whole of a transaction and while the cycle-time guard is still counting. The response side has no back-pressure: the host must take `rsp_valid` in the cycle it is high.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, the strobe outputs are as follows: `sram_cs_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. Its address and write data are latched on that edge, so later changes to the request fields have no effect. `req_ready` stays 0 until the transaction is over.
- R3: A read holds `sram_cs_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 for RD_CYC cycles. RD_CYC is the largest of the ceiling-divided access and output-enable times, and is 3 at defaults. The data input is captured on the last of those edges. `rsp_valid` rises 3 edges after the accepting edge at defaults, and `rsp_rdata` carries the word last written to that address.
- R4: A write runs as three phases. First comes one setup cycle with `sram_cs_n`=0, `sram_we_n`=1 and the bus undriven. Next, `sram_we_n`=0 for WP_CYC cycles with the bus driving the write data; WP_CYC is 2 at defaults, the largest of the ceiling-divided pulse width, data setup and address-to-end times. Last, one hold cycle with `sram_we_n`=1 and the bus still driven. `rsp_valid` rises 4 edges after the accepting edge at defaults.
- R5: `sram_oe_n` is 1 whenever `sram_we_n` is 0 or `sram_dq_oe` is 1, so the controller and the RAM never drive the bus at once.
- R6: After a read, the RAM is deselected with the bus undriven for TA_CYC cycles (2 at defaults, from the output turn-off time) before the block returns to idle. The next request is therefore accepted 6 edges after a read's accepting edge at defaults, and 5 after a write's.
- R7: Two accepting edges are never closer than RC_CYC cycles (the ceiling-divided cycle time). With a cycle time of 40 ns at a 4 ns clock, back-to-back writes are accepted 10 edges apart.
- R8: While no transaction is in progress (`req_ready`=1), `sram_cs_n` is 1, which keeps the RAM in standby.
- R9: `rsp_valid` is high for exactly one cycle per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a transaction |
| req_ready | output | 1 | Controller can accept a transaction |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Read data, valid with rsp_valid after a read |
| sram_addr | output | 20 | RAM address lines |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_o | output | 4 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Tri-state enable for sram_dq_o |
| sram_dq_i | input | 4 | Data received from the RAM |

## Verification
The assertions watch the strobe relationships on every cycle. They check that the write strobe only falls while the chip is selected, that output enable stays off during writes and whenever the bus is driven, and that address and write data stay steady while the strobes are active. They also check that the bus is still driven with select low on the edge where the write strobe rises, that the response pulse lasts one cycle, and that the RAM is deselected while ready is shown. The phase lengths, the response latencies, the read recovery and cycle-time spacing, and the correctness of data stored and read back through a memory model can only be shown by the bench's transaction scenarios.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RREC,
    ST_WSET,
    ST_WPUL,
    ST_WHLD
  } ctrl_st_t;

  // whole clock cycles covering t_ps, never fewer than one
  function automatic int unsigned cyc_ceil(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_gate.sv
module sram_cycle_gate #(
  parameter int RC_CYC = 3,
  localparam int GW = $clog2(RC_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic gate_open
);

  logic [GW-1:0] since_q;

  // cycles elapsed since the last accepting edge, saturating at RC_CYC
  always_ff @(posedge clk) begin
    if (!rst_n)
      since_q <= GW'(RC_CYC);
    else if (start)
      since_q <= GW'(1);
    else if (since_q < GW'(RC_CYC))
      since_q <= since_q + GW'(1);
  end

  assign gate_open = (since_q >= GW'(RC_CYC));

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 3,
  parameter int WP_CYC = 2,
  parameter int TA_CYC = 2,
  localparam int MAXC = (RD_CYC > WP_CYC) ? ((RD_CYC > TA_CYC) ? RD_CYC : TA_CYC)
                                          : ((WP_CYC > TA_CYC) ? WP_CYC : TA_CYC),
  localparam int CW = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_wr,
  input  logic gate_open,
  output logic req_ready,
  output logic capture,
  output logic rsp_valid,
  output logic cs_n,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe
);

  ctrl_st_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic last_cyc;

  assign last_cyc  = (cnt_q == '0);
  assign req_ready = (st_q == ST_IDLE) && gate_open;
  assign capture   = (st_q == ST_RD) && last_cyc;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d  = start_wr ? ST_WSET : ST_RD;
        cnt_d = start_wr ? '0 : CW'(RD_CYC - 1);
      end
      ST_RD: if (last_cyc) begin
        st_d  = ST_RREC;
        cnt_d = CW'(TA_CYC - 1);
      end else cnt_d = cnt_q - CW'(1);
      ST_RREC: if (last_cyc) st_d = ST_IDLE;
               else cnt_d = cnt_q - CW'(1);
      ST_WSET: begin
        st_d  = ST_WPUL;
        cnt_d = CW'(WP_CYC - 1);
      end
      ST_WPUL: if (last_cyc) st_d = ST_WHLD;
               else cnt_d = cnt_q - CW'(1);
      ST_WHLD: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // strobes are flops loaded from the decode of the next state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      cs_n      <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dq_oe     <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      cs_n      <= (st_d == ST_IDLE) || (st_d == ST_RREC);
      we_n      <= (st_d != ST_WPUL);
      oe_n      <= (st_d != ST_RD);
      dq_oe     <= (st_d == ST_WPUL) || (st_d == ST_WHLD);
      rsp_valid <= capture || (st_q == ST_WHLD);
    end
  end

  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> !cs_n); // R4
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> oe_n); // R5
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> oe_n); // R5
  AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n) $rose(we_n) |-> (dq_oe && !cs_n)); // R4
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R9
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> cs_n); // R8

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
  parameter int AW = 20,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] dq_i,
  input  logic          cs_n,
  input  logic          we_n,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr  <= '0;
      dq_o  <= '0;
      rdata <= '0;
    end else begin
      if (start) begin
        addr <= req_addr;
        dq_o <= req_wdata;
      end
      if (capture)
        rdata <= dq_i;
    end
  end

  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (!cs_n && $past(!cs_n)) |-> $stable(addr)); // R2
  AST_WDATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (!we_n && $past(!we_n)) |-> $stable(dq_o)); // R4

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 4,
  parameter int CLK_PS  = 4000,
  parameter int T_RC_PS = 10000,
  parameter int T_AA_PS = 10000,
  parameter int T_OE_PS = 5000,
  parameter int T_WP_PS = 8000,
  parameter int T_AW_PS = 8000,
  parameter int T_DW_PS = 6000,
  parameter int T_HZ_PS = 7000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int RC_CYC = int'(cyc_ceil(T_RC_PS, CLK_PS));
  localparam int RD_CYC = int'(umax(cyc_ceil(T_AA_PS, CLK_PS), cyc_ceil(T_OE_PS, CLK_PS)));
  // address is already valid during the one setup cycle before the pulse
  localparam int AW_CYC = int'(umax(cyc_ceil(T_AW_PS, CLK_PS) - 1, 1));
  localparam int WP_CYC = int'(umax(umax(cyc_ceil(T_WP_PS, CLK_PS), cyc_ceil(T_DW_PS, CLK_PS)),
                                    AW_CYC));
  localparam int TA_CYC = int'(cyc_ceil(T_HZ_PS, CLK_PS));

  logic start, gate_open, capture;

  assign start = req_valid && req_ready;

  sram_cycle_gate #(.RC_CYC(RC_CYC)) gate_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .gate_open (gate_open)
  );

  sram_seq #(.RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_wr  (req_write),
    .gate_open (gate_open),
    .req_ready (req_ready),
    .capture   (capture),
    .rsp_valid (rsp_valid),
    .cs_n      (sram_cs_n),
    .we_n      (sram_we_n),
    .oe_n      (sram_oe_n),
    .dq_oe     (sram_dq_oe)
  );

  sram_datapath #(.AW(ADDR_W), .DW(DATA_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_i      (sram_dq_i),
    .cs_n      (sram_cs_n),
    .we_n      (sram_we_n),
    .addr      (sram_addr),
    .dq_o      (sram_dq_o),
    .rdata     (rsp_rdata)
  );

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, cs_n, we_n, oe_n, dq_oe;
  logic [3:0]  rsp_rdata, dq_o, dq_i;
  logic [19:0] ram_addr;

  sram_async_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(ram_addr),
    .sram_cs_n(cs_n), .sram_we_n(we_n), .sram_oe_n(oe_n),
    .sram_dq_o(dq_o), .sram_dq_oe(dq_oe), .sram_dq_i(dq_i)
  );

  // second instance with a long cycle time for the spacing guard
  logic        s_ready, s_rsp, s_cs, s_we, s_oe, s_oe_dq;
  logic [3:0]  s_rd, s_dqo;
  logic [19:0] s_addr;
  logic        s_valid = 1'b0;
  sram_async_ctrl #(.T_RC_PS(40000)) slow_i (
    .clk(clk), .rst_n(rst_n), .req_valid(s_valid), .req_ready(s_ready),
    .req_write(1'b1), .req_addr(20'h00011), .req_wdata(4'h3),
    .rsp_valid(s_rsp), .rsp_rdata(s_rd), .sram_addr(s_addr),
    .sram_cs_n(s_cs), .sram_we_n(s_we), .sram_oe_n(s_oe),
    .sram_dq_o(s_dqo), .sram_dq_oe(s_oe_dq), .sram_dq_i(4'h0)
  );

  // behavioural RAM: latches on the rising write strobe, drives when read-enabled
  logic [3:0] mem [0:255];
  initial for (int i = 0; i < 256; i++) mem[i] = 4'h0;
  always @(posedge we_n) if (!cs_n) mem[ram_addr[7:0]] <= dq_o;
  assign dq_i = (!cs_n && !oe_n && we_n) ? mem[ram_addr[7:0]] : 4'hE;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // strobe run-length and rule monitors
  int we_cur = 0, we_last = 0, cs_cur = 0, cs_last = 0;
  int bus_bad = 0, idle_bad = 0, rsp_bad = 0;
  logic rsp_prev = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (!we_n) we_cur++; else if (we_cur != 0) begin we_last = we_cur; we_cur = 0; end
    if (!cs_n) cs_cur++; else if (cs_cur != 0) begin cs_last = cs_cur; cs_cur = 0; end
    if ((!we_n || dq_oe) && !oe_n) bus_bad++;
    if (req_ready && !cs_n) idle_bad++;
    if (rsp_valid && rsp_prev) rsp_bad++;
    rsp_prev = rsp_valid;
  end

  task automatic txn(input bit w, input logic [19:0] a, input logic [3:0] d,
                     output logic [3:0] q, output int lat, output int acc);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    acc = cyc;
    req_valid = 1'b0; req_addr = 20'h5A5A5; req_wdata = ~d;  // R2 fields changed after accept
    lat = 0;
    while (!rsp_valid && lat < 20) begin
      if (lat == 1) chk(!req_ready, "R2 ready low while busy", req_ready, 0);
      if (w && lat == 0) chk(!cs_n && we_n && !dq_oe, "R4 setup phase", {cs_n, we_n, dq_oe}, 3'b010);
      if (w && (lat == 1 || lat == 2))
        chk(!we_n && oe_n && dq_oe && dq_o == d, "R4 pulse phase drives data", dq_o, d);
      if (w && lat == 3) chk(we_n && dq_oe && !cs_n, "R4 hold phase", {cs_n, we_n, dq_oe}, 3'b011);
      lat++;
      @(negedge clk);
    end
    q = rsp_rdata;
  endtask

  localparam int NV = 9;
  // {write, addr, wdata, expected read data}
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 20'h00005, 4'h9, 4'h0},
    {1'b1, 20'h000A3, 4'h4, 4'h0},
    {1'b0, 20'h00005, 4'h0, 4'h9},
    {1'b1, 20'h00005, 4'hC, 4'h0},
    {1'b0, 20'h000A3, 4'h0, 4'h4},
    {1'b0, 20'h00005, 4'h0, 4'hC},
    {1'b1, 20'hFFFFF, 4'h7, 4'h0},
    {1'b0, 20'hFFFFF, 4'h0, 4'h7},
    {1'b0, 20'h00040, 4'h0, 4'h0}
  };

  bit timed_out = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    timed_out = 1'b1;
    fails++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] q;
    int lat, acc, acc2;
    int s_acc [2];
    int s_n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cs_n && we_n && oe_n && !dq_oe && !rsp_valid && req_ready, "R1 reset state",
        {cs_n, we_n, oe_n, dq_oe, rsp_valid, req_ready}, 6'b111001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && req_ready, "R1 state after reset release", {cs_n, req_ready}, 2'b11);

    for (int i = 0; i < NV; i++) begin
      txn(VEC[i][28], VEC[i][27:8], VEC[i][7:4], q, lat, acc);
      if (VEC[i][28]) begin
        chk(lat == 4, "R4 write latency", lat, 4);
        @(negedge clk);
        chk(we_last == 2, "R4 write pulse cycles", we_last, 2);
      end else begin
        chk(lat == 3, "R3 read latency", lat, 3);
        chk(q == VEC[i][3:0], "R3 read data", q, VEC[i][3:0]);
        @(negedge clk);
        chk(cs_last == 3, "R3 select cycles in read", cs_last, 3);
      end
    end

    // back-to-back spacing
    txn(1'b0, 20'h00005, 4'h0, q, lat, acc);
    txn(1'b0, 20'h000A3, 4'h0, q, lat, acc2);
    chk(acc2 - acc == 6, "R6 read recovery spacing", acc2 - acc, 6);
    chk(q == 4'h4, "R2 read of latched address", q, 4'h4);
    txn(1'b1, 20'h00010, 4'h1, q, lat, acc);
    txn(1'b1, 20'h00020, 4'h2, q, lat, acc2);
    chk(acc2 - acc == 5, "R6 write to next spacing", acc2 - acc, 5);

    // cycle-time guard on the slow instance: hold valid, record accepts
    s_n = 0;
    s_valid = 1'b1;
    while (s_n < 2) begin
      @(negedge clk);
      if (s_valid && s_ready) begin s_acc[s_n] = cyc; s_n++; end
    end
    s_valid = 1'b0;
    chk(s_acc[1] - s_acc[0] == 10, "R7 cycle-time spacing", s_acc[1] - s_acc[0], 10);

    repeat (12) @(negedge clk);
    chk(bus_bad == 0, "R5 output enable off while writing or driving", bus_bad, 0);
    chk(idle_bad == 0, "R8 deselected while idle", idle_bad, 0);
    chk(rsp_bad == 0, "R9 single-cycle response", rsp_bad, 0);
    chk(cs_n && !dq_oe, "R8 idle bus state", {cs_n, dq_oe}, 2'b10);

    if (!timed_out) begin
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule